// File: doc/BRIEF.md
# Input Capture Timer

This block timestamps edges on an external, asynchronous signal. A counter runs steadily on ticks from a programmable divider of the system clock, counting up or down. When the selected edge arrives on the capture pin, the block copies the counter value into a capture register that software can read. It also sets a sticky event flag, which drives the interrupt line, and gives a one-clock pulse.

Software measures the time between edges in one of two ways. It can subtract successive captures of the free-running count. Or it can turn on auto-clear: the counter and divider then restart at every capture, and each captured value is the interval since the previous capture, in ticks.

A four-word register window gives access to the control word, the status flags, the live count and the captured value. Reads are combinational. Writes take effect on the next clock edge.

Top module: `ict_capture_timer`

## Requirements
- R1: The control word sits at address 0. Bit 0 enables counting. The divider value DIV is in bits [8 +: DIV_W]. While enabled, the counter moves one step on each tick, and a tick occurs once every DIV+1 clocks. While disabled, the counter holds its value.
- R2: Control bit 1 selects the direction: 0 counts up and 1 counts down. The count wraps modulo 2^CNT_W in both directions: up from all-ones to zero, and down from zero to all-ones.
- R3: Status bit 2 (address 1) is a sticky wrap flag. It is set by every wrap of the counter. Writing 1 to that bit clears it.
- R4: The capture pin passes through two synchroniser flops and then a registered edge detector. The capture register and the one-clock `cap_pulse` output update on the third rising clock edge after the pin changes.
- R5: Control bit 2 selects the capture polarity: 0 means rising edges and 1 means falling edges. An edge of the other polarity causes no capture, leaves the capture register unchanged and sets no flag.
- R6: A capture copies the count that was current in the detection cycle into the capture register, read at address 3. The live count is read at address 2. Both are zero-extended to 32 bits.
- R7: Status bit 0 is a sticky capture flag, set by every capture. `irq` is high exactly while this flag is set. Writing 1 to the bit clears it, and a capture in the same cycle as that write wins.
- R8: Status bit 1 is a sticky overrun flag. It is set when a capture occurs while the capture flag is still set, and the capture register then takes the new value. Writing 1 to the bit clears it.
- R9: Control bit 3 turns on auto-clear. In this mode, a capture sets the counter to zero and restarts the divider, and that cycle gives no tick. For two captures G clocks apart, the second captured value is n = floor((G-1)/(DIV+1)) when counting up, and (2^CNT_W - n) mod 2^CNT_W when counting down.
- R10: After reset, all four register words read zero, and `irq` and `cap_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_in | input | 1 | Asynchronous capture pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select: 0 control, 1 status, 2 count, 3 capture |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| cap_pulse | output | 1 | One-clock pulse per capture |
| irq | output | 1 | Interrupt, equal to the sticky capture flag |

## Verification
The hardest result to reach from the ports is an exact auto-clear interval. The edges are asynchronous, and the divider phase at the first edge is otherwise unknown. The bench drives each pair of rising edges a fixed number of clocks apart, always on the falling clock edge. Both edges then cross the same synchroniser pipeline, so they are detected exactly G cycles apart. A table of divider, gap and direction settings then pins down the captured count, including intervals of zero and one tick. A down-count wrap from the reset value exercises the wrap flag without running through a full counter period.

// File: rtl/ict_pkg.sv
package ict_pkg;
  localparam int DW = 32;

  // control word bit positions
  localparam int CTL_EN      = 0;
  localparam int CTL_DOWN    = 1;
  localparam int CTL_FALL    = 2;
  localparam int CTL_AUTO    = 3;
  localparam int CTL_DIV_LSB = 8;

  // status word bit positions
  localparam int ST_CAP  = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_WRAP = 2;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_CAPT  = 2'd3
  } reg_sel_e;

  function automatic logic [DW-1:0] width_mask(input int w);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < DW; i++) begin
      if (i < w) m[i] = 1'b1;
    end
    return m;
  endfunction

  // one counter step in the chosen direction, wrapped to w bits
  function automatic logic [DW-1:0] step_count(input logic [DW-1:0] c,
                                                input logic dn, input int w);
    logic [DW-1:0] r;
    r = dn ? (c - 32'd1) : (c + 32'd1);
    return r & width_mask(w);
  endfunction

  // true when the next step in the chosen direction wraps
  function automatic logic at_limit(input logic [DW-1:0] c,
                                    input logic dn, input int w);
    return dn ? (c == '0) : (c == width_mask(w));
  endfunction

  function automatic logic edge_match(input logic now_v, input logic before_v,
                                      input logic fall);
    return fall ? (before_v & ~now_v) : (now_v & ~before_v);
  endfunction
endpackage

// File: rtl/ict_sync_edge.sv
module ict_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall,
  output logic edge_hit
);
  import ict_pkg::*;

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= pin;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[TOP];
  end

  assign edge_hit = edge_match(chain[TOP], prev, fall);
endmodule

// File: rtl/ict_prescaler.sv
module ict_prescaler #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase;

  assign tick = en && !restart && (phase == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase <= '0;
    else if (restart || !en)    phase <= '0;
    else if (phase == div)      phase <= '0;
    else                        phase <= phase + 1'b1;
  end
endmodule

// File: rtl/ict_counter.sv
module ict_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             down,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt
);
  import ict_pkg::*;

  logic [DW-1:0]    cur_full;
  logic [DW-1:0]    nxt_full;
  logic [CNT_W-1:0] nxt;
  logic             unused_hi;

  assign cur_full  = DW'(count);
  assign nxt_full  = step_count(cur_full, down, CNT_W);
  assign nxt       = nxt_full[CNT_W-1:0];
  assign unused_hi = ^nxt_full;
  assign wrap_evt  = tick && !clear && at_limit(cur_full, down, CNT_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (tick)  count <= nxt;
  end
endmodule

// File: rtl/ict_capture_timer.sv
module ict_capture_timer #(
  parameter int CNT_W       = 16,
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_in,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cap_pulse,
  output logic        irq
);
  import ict_pkg::*;

  localparam int CTL_TOP = CTL_DIV_LSB + DIV_W;

  // control fields
  logic             ctl_en, ctl_down, ctl_fall, ctl_auto;
  logic [DIV_W-1:0] ctl_div;

  // named internal events
  logic             cap_evt;
  logic             tick;
  logic             restart;
  logic             wrap_evt;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q;
  logic             flag_cap, flag_ovr, flag_wrap;
  logic             cap_pulse_q;

  logic             wr_ctrl, wr_stat;
  logic [2:0]       clr;
  reg_sel_e         sel;
  logic             unused_wdata;

  assign sel          = reg_sel_e'(reg_addr);
  assign wr_ctrl      = reg_we && (sel == SEL_CTRL);
  assign wr_stat      = reg_we && (sel == SEL_STAT);
  assign clr          = wr_stat ? reg_wdata[2:0] : 3'b000;
  assign restart      = cap_evt && ctl_auto;
  assign unused_wdata = ^{reg_wdata[31:CTL_TOP], reg_wdata[CTL_DIV_LSB-1:4]};

  ict_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (cap_in),
    .fall     (ctl_fall),
    .edge_hit (cap_evt)
  );

  ict_prescaler #(.DIV_W(DIV_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctl_en),
    .restart (restart),
    .div     (ctl_div),
    .tick    (tick)
  );

  ict_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .down     (ctl_down),
    .clear    (restart),
    .count    (cnt_q),
    .wrap_evt (wrap_evt)
  );

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_down <= 1'b0;
      ctl_fall <= 1'b0;
      ctl_auto <= 1'b0;
      ctl_div  <= '0;
    end else if (wr_ctrl) begin
      ctl_en   <= reg_wdata[CTL_EN];
      ctl_down <= reg_wdata[CTL_DOWN];
      ctl_fall <= reg_wdata[CTL_FALL];
      ctl_auto <= reg_wdata[CTL_AUTO];
      ctl_div  <= reg_wdata[CTL_DIV_LSB +: DIV_W];
    end
  end

  // capture latch and event pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q       <= '0;
      cap_pulse_q <= 1'b0;
    end else begin
      cap_pulse_q <= cap_evt;
      if (cap_evt) cap_q <= cnt_q;
    end
  end

  // sticky flags: a new event wins over a write-1 clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_cap  <= 1'b0;
      flag_ovr  <= 1'b0;
      flag_wrap <= 1'b0;
    end else begin
      flag_cap  <= cap_evt | (flag_cap & ~clr[ST_CAP]);
      flag_ovr  <= (cap_evt & flag_cap) | (flag_ovr & ~clr[ST_OVR]);
      flag_wrap <= wrap_evt | (flag_wrap & ~clr[ST_WRAP]);
    end
  end

  // register readback
  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_CTRL: begin
        reg_rdata[CTL_EN]                  = ctl_en;
        reg_rdata[CTL_DOWN]                = ctl_down;
        reg_rdata[CTL_FALL]                = ctl_fall;
        reg_rdata[CTL_AUTO]                = ctl_auto;
        reg_rdata[CTL_DIV_LSB +: DIV_W]    = ctl_div;
      end
      SEL_STAT: begin
        reg_rdata[ST_CAP]  = flag_cap;
        reg_rdata[ST_OVR]  = flag_ovr;
        reg_rdata[ST_WRAP] = flag_wrap;
      end
      SEL_COUNT: reg_rdata[CNT_W-1:0] = cnt_q;
      SEL_CAPT:  reg_rdata[CNT_W-1:0] = cap_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign cap_pulse = cap_pulse_q;
  assign irq       = flag_cap;
endmodule

// File: rtl/ict_capture_timer_chk.sv
module ict_capture_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_evt,
  input logic             tick,
  input logic             restart,
  input logic             wrap_evt,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cap_q,
  input logic             flag_cap,
  input logic             flag_ovr,
  input logic             flag_wrap,
  input logic             cap_pulse
);
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt_q)); // R1

  AST_WRAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag_wrap); // R3

  AST_PULSE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_pulse); // R4

  AST_CAPTURE_COPIES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(cnt_q))); // R6

  AST_CAPTURE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag_cap); // R7

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && flag_cap) |=> flag_ovr); // R8

  AST_AUTOCLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R9
endmodule

bind ict_capture_timer ict_capture_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cap_evt   (cap_evt),
  .tick      (tick),
  .restart   (restart),
  .wrap_evt  (wrap_evt),
  .cnt_q     (cnt_q),
  .cap_q     (cap_q),
  .flag_cap  (flag_cap),
  .flag_ovr  (flag_ovr),
  .flag_wrap (flag_wrap),
  .cap_pulse (cap_pulse)
);

// File: tb/ict_capture_timer_tb_top.sv
module ict_capture_timer_tb_top;
  localparam int CW   = 8;
  localparam int MOD  = 1 << CW;
  localparam int NVEC = 7;
  // {divider, gap in clocks, down}
  localparam int VEC [NVEC][3] = '{
    '{0, 5, 0}, '{0, 20, 1}, '{1, 9, 0}, '{3, 17, 0},
    '{2, 30, 1}, '{0, 2, 0}, '{3, 3, 0}
  };
  localparam logic [31:0] C_EN = 32'h1, C_DN = 32'h2, C_FALL = 32'h4, C_AUTO = 32'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_in = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cap_pulse, irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ict_capture_timer #(.CNT_W(CW), .DIV_W(4), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_pulse(cap_pulse), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rise_pulse();
    cap_in = 1'b1;
    @(negedge clk);
    cap_in = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic int expect_interval(input int div, input int gap, input int dn);
    int n;
    n = (gap - 1) / (div + 1);
    return dn != 0 ? (MOD - n) % MOD : n;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [31:0] v, c1, c2, a0;
    do_reset();

    // R10 reset state
    rd(2'd0, v); check("R10 ctrl", v, 0);
    rd(2'd1, v); check("R10 status", v, 0);
    rd(2'd2, v); check("R10 count", v, 0);
    rd(2'd3, v); check("R10 capture", v, 0);
    check("R10 irq", {31'd0, irq}, 0);
    check("R10 cap_pulse", {31'd0, cap_pulse}, 0);

    // R1 disabled counter holds
    repeat (5) @(negedge clk);
    rd(2'd2, v); check("R1 hold while disabled", v, 0);

    // R1 counting up at divider 0
    wr(2'd0, C_EN);
    repeat (10) @(negedge clk);
    rd(2'd2, v); check("R1 ten ticks", v, 10);

    // R1 divider 3: exactly 3 ticks per 12 clocks
    wr(2'd0, C_EN | (32'd3 << 8));
    rd(2'd2, c1);
    repeat (12) @(negedge clk);
    rd(2'd2, c2); check("R1 prescaled rate", (c2 - c1) & 32'hFF, 3);

    // R2/R3 down count wraps from zero
    do_reset();
    wr(2'd0, C_EN | C_DN);
    @(negedge clk);
    rd(2'd2, v); check("R2 down wrap to max", v, 255);
    rd(2'd1, v); check("R3 wrap flag on down wrap", v, 4);
    repeat (5) @(negedge clk);
    rd(2'd2, v); check("R2 down counting", v, 250);
    wr(2'd1, 32'd4);
    rd(2'd1, v); check("R3 wrap flag cleared", v, 0);

    // R2/R3 up count wraps from max
    wr(2'd0, C_EN);
    rd(2'd2, c1);
    repeat (MOD - int'(c1) + 1) @(negedge clk);
    rd(2'd2, v); check("R2 up wrap modulo", v, 1);
    rd(2'd1, v); check("R3 wrap flag on up wrap", v, 4);

    // R4 latency and pulse width, R7 irq
    wr(2'd1, 32'd7);
    cap_in = 1'b1;
    @(negedge clk); check("R4 no pulse after 1 edge", {31'd0, cap_pulse}, 0);
    @(negedge clk); check("R4 no pulse after 2 edges", {31'd0, cap_pulse}, 0);
    @(negedge clk); check("R4 pulse after 3 edges", {31'd0, cap_pulse}, 1);
    check("R7 irq follows flag", {31'd0, irq}, 1);
    cap_in = 1'b0;
    @(negedge clk); check("R4 pulse lasts one clock", {31'd0, cap_pulse}, 0);

    // R6 free-running captures G clocks apart, R8 overrun
    wr(2'd1, 32'd7);
    repeat (4) @(negedge clk);
    rise_pulse();
    repeat (3) @(negedge clk);
    rd(2'd3, c1);
    repeat (37 - 4) @(negedge clk);
    rise_pulse();
    repeat (3) @(negedge clk);
    rd(2'd3, c2); check("R6 capture difference", (c2 - c1) & 32'hFF, 37);
    rd(2'd1, v); check("R8 overrun on second capture", v & 3, 3);
    wr(2'd1, 32'd1);
    rd(2'd1, v); check("R7 clear capture flag only", v & 3, 2);
    check("R7 irq low after clear", {31'd0, irq}, 0);
    wr(2'd1, 32'd2);
    rd(2'd1, v); check("R8 overrun cleared", v & 3, 0);

    // R5 falling polarity ignores rising edge
    wr(2'd0, C_EN | C_FALL);
    wr(2'd1, 32'd7);
    rd(2'd3, a0);
    cap_in = 1'b1;
    repeat (5) @(negedge clk);
    rd(2'd1, v); check("R5 rising edge ignored flag", v & 1, 0);
    rd(2'd3, v); check("R5 rising edge ignored capture", v, a0);
    check("R5 rising edge no irq", {31'd0, irq}, 0);
    cap_in = 1'b0;
    repeat (4) @(negedge clk);
    rd(2'd1, v); check("R5 falling edge captured", v & 1, 1);

    // R9 auto-clear interval table
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, C_EN | C_AUTO | (VEC[i][2] != 0 ? C_DN : 32'd0) | (32'(VEC[i][0]) << 8));
      wr(2'd1, 32'd7);
      repeat (3) @(negedge clk);
      rise_pulse();
      repeat (VEC[i][1] - 1) @(negedge clk);
      rise_pulse();
      repeat (4) @(negedge clk);
      rd(2'd3, v);
      check($sformatf("R9 interval vector %0d", i), v,
            32'(expect_interval(VEC[i][0], VEC[i][1], VEC[i][2])));
    end

    finish_run();
  end
endmodule